// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core

This block is a small 32-bit processor that finishes every instruction in one clock period. It fetches a word from an instruction port addressed by the program counter, decodes it in two stages, and then computes and commits the result. The first stage is a main decoder driven by the opcode. The second is a local ALU decoder driven by a 3-bit operation class and the function field. Its state is the program counter, a 32-entry register bank and the external data memory, and all of it updates on the falling clock edge. Reads from the register bank and both memory ports are combinational.

The supported operations are:
- register add, subtract, AND, OR and signed set-less-than
- OR with a zero-extended immediate
- word load and word store, addressed as base plus a sign-extended offset
- branch on equal
- absolute jump

Any other opcode behaves as a no-op: the PC advances and nothing is written. Debug outputs report the PC and every register write, so a reference model can follow the core instruction by instruction.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset, sampled on the falling edge, sets the PC to 0 and clears every register to 0.
- R2: Any instruction other than a taken branch or a jump moves the PC to PC+4 at the next falling edge.
- R3: Opcode 000000 with function 100000 writes rs+rt to register rd. With function 100010 it writes rs-rt to rd (modulo 2^32).
- R4: Opcode 001101 writes rs OR zero-extended imm[15:0] to register rt.
- R5: Opcode 100011 reads data memory at rs + sign-extended imm and writes that word to register rt.
- R6: Opcode 101011 drives the data write enable with address rs + sign-extended imm and write data rt. It writes no register.
- R7: Opcode 000100 compares rs with rt. If they are equal, the next PC is PC+4 + (sign-extended imm << 2); otherwise it is PC+4. It writes nothing.
- R8: Opcode 000010 sets the PC to {(PC+4)[31:28], target[25:0], 00}. It writes nothing.
- R9: Register 0 always reads as 0. A write aimed at it does not happen, and the register write enable stays low.
- R10: Any opcode outside the set above leaves every register and memory word unchanged and advances the PC by 4.
- R11: Opcode 000000 with function 100100 writes rs AND rt to rd. Function 100101 writes rs OR rt. Function 101010 writes 1 if rs < rt as signed values and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the falling edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Instruction fetch address (the PC) |
| imem_data | input | 32 | Instruction word at imem_addr |
| dmem_addr | output | 32 | Data memory word address (ALU result) |
| dmem_wdata | output | 32 | Store data (register rt) |
| dmem_we | output | 1 | Data memory write enable |
| dmem_rdata | input | 32 | Data memory read word at dmem_addr |
| dbg_pc | output | 32 | Current PC |
| dbg_rf_we | output | 1 | A register write takes effect at the next falling edge |
| dbg_rf_waddr | output | 5 | Register being written |
| dbg_rf_wdata | output | 32 | Value being written |

## Verification
A corrupted register value stays hidden until a later instruction reads that register. The first write, store or branch that uses it then shows the wrong value on the debug or data ports in the same cycle. Because every instruction is compared as it executes, the fault is reported at the first consumer, not at the end of the program. A wrong next-PC shows at dbg_pc one falling edge after the branch or jump, before any further instruction is committed. A wrong ALU class from the main decoder shows on the very instruction that was decoded wrongly.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_LW    = 6'b100011;
  localparam logic [5:0] OP_SW    = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  // operation class from the main decoder
  localparam logic [2:0] CLS_FUNCT = 3'b100;
  localparam logic [2:0] CLS_OR    = 3'b010;
  localparam logic [2:0] CLS_ADD   = 3'b000;
  localparam logic [2:0] CLS_SUB   = 3'b001;

  typedef enum logic [2:0] {
    ALU_ADD = 3'b000,
    ALU_SUB = 3'b001,
    ALU_AND = 3'b010,
    ALU_OR  = 3'b110,
    ALU_SLT = 3'b111
  } alu_fn_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       rf_write;
    logic       mem_write;
    logic       is_branch;
    logic       is_jump;
    logic       imm_signed;
    logic [2:0] op_class;
  } ctrl_t;

  function automatic logic known_op(input logic [5:0] op);
    return (op == OP_RTYPE) || (op == OP_ORI) || (op == OP_LW) ||
           (op == OP_SW) || (op == OP_BEQ) || (op == OP_J);
  endfunction

  function automatic logic [XLEN-1:0] imm_extend(input logic [15:0] imm,
                                                 input logic sgn);
    return sgn ? {{(XLEN-16){imm[15]}}, imm} : {{(XLEN-16){1'b0}}, imm};
  endfunction

  function automatic logic [XLEN-1:0] branch_dest(input logic [XLEN-1:0] seq,
                                                  input logic [XLEN-1:0] ext);
    return seq + {ext[XLEN-3:0], 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] jump_dest(input logic [XLEN-1:0] seq,
                                                input logic [25:0] tgt);
    return {seq[XLEN-1:28], tgt, 2'b00};
  endfunction

  function automatic logic [XLEN-1:0] alu_eval(input alu_fn_e fn,
                                               input logic [XLEN-1:0] a,
                                               input logic [XLEN-1:0] b);
    logic [XLEN-1:0] r;
    case (fn)
      ALU_ADD: r = a + b;
      ALU_SUB: r = a - b;
      ALU_AND: r = a & b;
      ALU_OR:  r = a | b;
      ALU_SLT: r = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
      default: r = a + b;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
  import sc_pkg::*;
(
  input  logic [5:0] op,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    case (op)
      OP_RTYPE: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.rf_write  = 1'b1;
        ctrl.op_class  = CLS_FUNCT;
      end
      OP_ORI: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.rf_write = 1'b1;
        ctrl.op_class = CLS_OR;
      end
      OP_LW: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.rf_write    = 1'b1;
        ctrl.imm_signed  = 1'b1;
        ctrl.op_class    = CLS_ADD;
      end
      OP_SW: begin
        ctrl.b_is_imm   = 1'b1;
        ctrl.mem_write  = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.op_class   = CLS_ADD;
      end
      OP_BEQ: begin
        ctrl.is_branch  = 1'b1;
        ctrl.imm_signed = 1'b1;
        ctrl.op_class   = CLS_SUB;
      end
      OP_J: ctrl.is_jump = 1'b1;
      default: ctrl = '0;
    endcase
  end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
  import sc_pkg::*;
(
  input  logic [2:0] op_class,
  input  logic [5:0] funct,
  output alu_fn_e    fn
);
  always_comb begin
    if (op_class[2]) begin
      case (funct[3:0])
        4'b0000: fn = ALU_ADD;
        4'b0010: fn = ALU_SUB;
        4'b0100: fn = ALU_AND;
        4'b0101: fn = ALU_OR;
        4'b1010: fn = ALU_SLT;
        default: fn = ALU_ADD;
      endcase
    end else if (op_class[1]) begin
      fn = ALU_OR;
    end else if (op_class[0]) begin
      fn = ALU_SUB;
    end else begin
      fn = ALU_ADD;
    end
  end
endmodule

// File: rtl/sc_regbank.sv
module sc_regbank #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  qa,
  output logic [W-1:0]  qb,
  output logic          wr_fire
);
  logic [W-1:0] q [NREGS];

  assign wr_fire = we && (wa != '0);
  assign q[0]    = '0;

  for (genvar i = 1; i < NREGS; i++) begin : g_reg
    always_ff @(negedge clk) begin
      if (rst)
        q[i] <= '0;
      else if (wr_fire && (wa == AW'(i)))
        q[i] <= wd;
    end
  end

  assign qa = q[ra];
  assign qb = q[rb];
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int NREGS = 32
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  output logic        dmem_we,
  input  logic [31:0] dmem_rdata,
  output logic [31:0] dbg_pc,
  output logic        dbg_rf_we,
  output logic [4:0]  dbg_rf_waddr,
  output logic [31:0] dbg_rf_wdata
);
  localparam int AW = $clog2(NREGS);

  logic [XLEN-1:0] pc, pc_seq, pc_next, imm_x, opnd_a, opnd_b, reg_b, alu_y, wb_val;
  logic [5:0]      f_op, f_funct;
  logic [4:0]      f_rs, f_rt, f_rd, dst;
  logic [15:0]     f_imm;
  logic [25:0]     f_tgt;
  logic            alu_zero, br_taken, rf_commit;
  ctrl_t           ctrl;
  alu_fn_e         fn;

  assign f_op    = imem_data[31:26];
  assign f_rs    = imem_data[25:21];
  assign f_rt    = imem_data[20:16];
  assign f_rd    = imem_data[15:11];
  assign f_funct = imem_data[5:0];
  assign f_imm   = imem_data[15:0];
  assign f_tgt   = imem_data[25:0];

  sc_main_dec u_mdec (.op(f_op), .ctrl(ctrl));
  sc_alu_dec  u_adec (.op_class(ctrl.op_class), .funct(f_funct), .fn(fn));

  assign dst    = ctrl.dst_is_rd ? f_rd : f_rt;
  assign imm_x  = imm_extend(f_imm, ctrl.imm_signed);

  sc_regbank #(.NREGS(NREGS), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .ra(f_rs[AW-1:0]), .rb(f_rt[AW-1:0]),
    .we(ctrl.rf_write), .wa(dst[AW-1:0]), .wd(wb_val),
    .qa(opnd_a), .qb(reg_b), .wr_fire(rf_commit)
  );

  assign opnd_b   = ctrl.b_is_imm ? imm_x : reg_b;
  assign alu_y    = alu_eval(fn, opnd_a, opnd_b);
  assign alu_zero = (alu_y == '0);
  assign wb_val   = ctrl.wb_from_mem ? dmem_rdata : alu_y;

  assign pc_seq   = pc + 32'd4;
  assign br_taken = ctrl.is_branch && alu_zero;
  always_comb begin
    if (ctrl.is_jump)   pc_next = jump_dest(pc_seq, f_tgt);
    else if (br_taken)  pc_next = branch_dest(pc_seq, imm_x);
    else                pc_next = pc_seq;
  end

  always_ff @(negedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign imem_addr    = pc;
  assign dmem_addr    = alu_y;
  assign dmem_wdata   = reg_b;
  assign dmem_we      = ctrl.mem_write && !rst;
  assign dbg_pc       = pc;
  assign dbg_rf_we    = rf_commit && !rst;
  assign dbg_rf_waddr = dst;
  assign dbg_rf_wdata = wb_val;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
  import sc_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic [31:0] imem_data,
  input logic [31:0] dbg_pc,
  input logic        dbg_rf_we,
  input logic [4:0]  dbg_rf_waddr,
  input logic        dmem_we
);
  logic [5:0] op;
  assign op = imem_data[31:26];

  a_r1_reset_pc: assert property (@(negedge clk) rst |=> (dbg_pc == 32'd0));

  a_r2_seq_pc: assert property (@(negedge clk) disable iff (rst)
    (op != OP_BEQ && op != OP_J) |=> (dbg_pc == $past(dbg_pc) + 32'd4));

  a_r6_store_only: assert property (@(negedge clk) disable iff (rst)
    (op == OP_SW) |-> (dmem_we && !dbg_rf_we));

  a_r8_jump_dest: assert property (@(negedge clk) disable iff (rst)
    (op == OP_J) |=> (dbg_pc[27:0] == {$past(imem_data[25:0]), 2'b00}));

  a_r9_no_zero_write: assert property (@(negedge clk) disable iff (rst)
    dbg_rf_we |-> (dbg_rf_waddr != 5'd0));

  a_r10_unknown_quiet: assert property (@(negedge clk) disable iff (rst)
    !known_op(op) |-> (!dbg_rf_we && !dmem_we));
endmodule

bind sc_core sc_core_chk u_chk (
  .clk(clk), .rst(rst), .imem_data(imem_data), .dbg_pc(dbg_pc),
  .dbg_rf_we(dbg_rf_we), .dbg_rf_waddr(dbg_rf_waddr), .dmem_we(dmem_we)
);

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dbg_rf_we;
  logic [31:0] dbg_pc, dbg_rf_wdata;
  logic [4:0]  dbg_rf_waddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [31:0] imem [256];
  logic [31:0] dmem [256];
  logic [31:0] rmem [256];
  logic [31:0] rreg [32];
  logic [31:0] rpc;

  always #5 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we),
    .dmem_rdata(dmem_rdata), .dbg_pc(dbg_pc), .dbg_rf_we(dbg_rf_we),
    .dbg_rf_waddr(dbg_rf_waddr), .dbg_rf_wdata(dbg_rf_wdata)
  );

  assign imem_data  = imem[imem_addr[9:2]];
  assign dmem_rdata = dmem[dmem_addr[9:2]];
  always @(negedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sx(logic [15:0] v);
    return {{16{v[15]}}, v};
  endfunction

  string pc_tag = "R1";

  // reference step: check current outputs against the instruction at rpc, then advance
  task automatic step();
    logic [31:0] ins, a, b, res, npc;
    logic [5:0] op, fn;
    int rs, rt, rd, dst;
    logic we, mwe;
    string tag;
    ins = imem[rpc[9:2]];
    op = ins[31:26]; fn = ins[5:0];
    rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
    a = rreg[rs]; b = rreg[rt];
    we = 0; mwe = 0; dst = 0; res = 0; npc = rpc + 4; tag = "R10";
    check(pc_tag, dbg_pc, rpc);
    case (op)
      6'b000000: begin
        dst = rd; we = 1;
        case (fn)
          6'b100000: begin res = a + b; tag = "R3"; end
          6'b100010: begin res = a - b; tag = "R3"; end
          6'b100100: begin res = a & b; tag = "R11"; end
          6'b100101: begin res = a | b; tag = "R11"; end
          default:   begin res = ($signed(a) < $signed(b)) ? 1 : 0; tag = "R11"; end
        endcase
      end
      6'b001101: begin dst = rt; we = 1; res = a | {16'h0, ins[15:0]}; tag = "R4"; end
      6'b100011: begin dst = rt; we = 1; res = rmem[(a + sx(ins[15:0])) >> 2 & 255]; tag = "R5"; end
      6'b101011: begin mwe = 1; tag = "R6"; end
      6'b000100: begin tag = "R7"; if (a == b) npc = rpc + 4 + (sx(ins[15:0]) << 2); end
      6'b000010: begin tag = "R8"; npc = {npc[31:28], ins[25:0], 2'b00}; end
      default: ;
    endcase
    if (we && dst == 0) begin we = 0; tag = "R9"; end
    check(tag, {31'd0, dbg_rf_we}, {31'd0, we});
    if (we) begin
      check(tag, {27'd0, dbg_rf_waddr}, 32'(dst));
      check(tag, dbg_rf_wdata, res);
    end
    check(tag, {31'd0, dmem_we}, {31'd0, mwe});
    if (mwe) begin
      check(tag, dmem_addr, a + sx(ins[15:0]));
      check(tag, dmem_wdata, b);
      rmem[((a + sx(ins[15:0])) >> 2) & 255] = b;
    end
    if (we) rreg[dst] = res;
    pc_tag = (op == 6'b000100 || op == 6'b000010) ? tag : "R2";
    rpc = npc;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    int p;
    logic [15:0] va, vb;
    for (int i = 0; i < 256; i++) begin
      imem[i] = 32'hFC00_0000;
      dmem[i] = 32'(i * 3 + 1);
      rmem[i] = 32'(i * 3 + 1);
    end
    for (int i = 0; i < 32; i++) rreg[i] = 0;
    p = 0;
    imem[p++] = enc_r(20, 21, 15, 6'b100000);        // R1: cleared regs
    imem[p++] = enc_i(6'b001101, 0, 6, 16'h0100);    // base
    imem[p++] = enc_i(6'b001101, 0, 0, 16'h0055);    // R9
    imem[p++] = enc_r(0, 0, 7, 6'b100000);           // R9 read r0
    imem[p++] = enc_i(6'b100011, 0, 11, 16'h0010);   // R5 preloaded word
    for (int k = 0; k < 12; k++) begin
      va = 16'((k * 16'h1357) ^ 16'h8001);
      vb = (k % 3 == 0) ? va : 16'(k * 16'h0ACE);
      imem[p++] = enc_i(6'b001101, 0, 1, va);
      imem[p++] = enc_i(6'b001101, 0, 2, vb);
      imem[p++] = enc_r(1, 2, 3, 6'b100000);
      imem[p++] = enc_r(1, 2, 4, 6'b100010);
      imem[p++] = enc_r(1, 2, 8, 6'b100100);
      imem[p++] = enc_r(3, 4, 9, 6'b100101);
      imem[p++] = enc_r(4, 1, 10, 6'b101010);
      imem[p++] = enc_i(6'b101011, 6, 3, 16'(-(k * 4)));
      imem[p++] = enc_i(6'b100011, 6, 5, 16'(-(k * 4)));
      imem[p++] = enc_i(6'b000100, 1, 2, 16'h0001);
      imem[p++] = enc_i(6'b001101, 0, 12, 16'hDEAD);
      imem[p++] = {6'b111111, 5'd1, 5'd13, 16'h7777}; // R10
    end
    imem[p] = {6'b000010, 26'(p + 2)};               // R8 forward jump
    p++;
    imem[p++] = enc_i(6'b001101, 0, 14, 16'hBAD0);
    imem[p] = {6'b000010, 26'(p)};                   // halt
    p++;

    rpc = 0;
    repeat (3) @(negedge clk);
    @(posedge clk);
    #1 check("R1", dbg_pc, 32'd0);
    check("R1", {31'd0, dbg_rf_we}, 32'd0);
    rst = 1'b0;
    for (int c = 0; c < p + 40; c++) begin
      #1 step();
      @(posedge clk);
    end
    finish_run();
  end
endmodule